// File: doc/BRIEF.md
# Seconds-and-Ticks Timebase with Pulse Capture

This block keeps a 64-bit notion of time as two 32-bit halves: a whole-seconds count and a sub-second tick count. The tick count advances once per clock. When it reaches a programmable tick rate, it returns to zero and carries into the seconds count. Software supplies a new time through a small write-only settings port. A write to the load-control setting commits that time. The commit happens either in the same clock edge or on the next qualifying edge of a once-per-second pulse.

The pulse is taken from one of two inputs, index 0 for the board connector and index 1 for a neighbouring unit. A flag selects whether the rising or the falling edge counts. On every qualifying edge the block captures the time it held just before that edge. The current time and the captured time are both read back through a combinational 32-bit readback port addressed by byte offset.

Top module: `tk_timebase`

## Requirements
- R1: While reset is asserted and on the first cycles after it, all four readback words read zero and no deferred load is armed.
- R2: Settings are selected by `cfg_addr`: 0 pending seconds, 1 pending ticks, 2 flags, 3 load control, 4 tick rate. A written tick rate governs every clock edge after the write edge.
- R3: Writing the pending seconds, pending ticks, flags or tick rate never changes the running seconds or ticks.
- R4: Outside a load, ticks increase by one per clock. When ticks plus one reaches or exceeds the tick rate, ticks become 0 and seconds increase by one. A rate of 0 or 1 therefore advances seconds every clock.
- R5: A load-control write with data bit 0 set makes the running time equal the pending seconds and ticks on the next cycle, and it cancels any armed deferred load.
- R6: A load-control write with data bit 0 clear arms a deferred load. The first qualifying pulse edge loads the pending time and disarms. Later edges do not reload.
- R7: Flags bit 0 selects the qualifying polarity: 1 means rising, 0 means falling. Edges of the other polarity are ignored.
- R8: Flags bit 1 selects the pulse source: 0 means `pps_in[0]` and 1 means `pps_in[1]`. Edges on the unselected input are ignored.
- R9: On every qualifying edge, the captured seconds and ticks take the running time of the cycle before the update. Without a qualifying edge, they hold their value.
- R10: A pulse input change applied between clock edges takes effect at the third rising clock edge after it. The path is two synchroniser stages followed by one edge-detect stage.
- R11: `rd_addr[3:2]` selects the readback word: 0 running seconds, 1 running ticks, 2 captured seconds, 3 captured ticks. `rd_addr[1:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Settings write strobe |
| cfg_addr | input | 3 | Settings select |
| cfg_wdata | input | 32 | Settings write data |
| pps_in | input | 2 | Pulse inputs: bit 0 connector, bit 1 neighbour unit |
| rd_addr | input | 4 | Readback byte offset |
| rd_data | output | 32 | Readback word |

## Verification
The assertions check the following on every cycle:
- the tick increment and the carry into seconds;
- the immediate load and its cancelling of an armed load;
- the deferred load and its disarm on a qualifying edge;
- the capture of the pre-edge time, and the holding of the captured time between qualifying edges.

They start from the internal pulse-qualify signal, so they cannot show that the right edge was qualified. Polarity choice, source choice, the three-edge latency from a pin change and the readback byte decode are shown only by bench scenarios. In those scenarios the bench predicts the time on exact cycles and compares it at the readback port.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int unsigned CFG_AW = 3;

  typedef enum logic [CFG_AW-1:0] {
    CFG_PEND_SECS  = 3'd0,
    CFG_PEND_TICKS = 3'd1,
    CFG_FLAGS      = 3'd2,
    CFG_LOAD       = 3'd3,
    CFG_TPS        = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    RB_NOW_SECS  = 2'd0,
    RB_NOW_TICKS = 2'd1,
    RB_CAP_SECS  = 2'd2,
    RB_CAP_TICKS = 2'd3
  } rb_sel_e;

  localparam int unsigned FLAG_POL_BIT = 0;
  localparam int unsigned FLAG_SRC_LSB = 1;

endpackage

// File: rtl/tk_rst_sync.sv
module tk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tk_pps_sel.sv
module tk_pps_sel #(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SRC_W       = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pps_in,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               rise_pol,
  output logic               pps_hit
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_SRC-1:0] rise_v;
  logic [NUM_SRC-1:0] fall_v;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN_W-2:0], pps_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    // edge seen between the last synchroniser stage and its delayed copy
    assign rise_v[g] = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    assign fall_v[g] = ~chain_q[CHAIN_W-2] & chain_q[CHAIN_W-1];
  end

  logic sel_valid;
  logic edge_pick;

  always_comb begin
    sel_valid = (int'(src_sel) < NUM_SRC);
    edge_pick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(src_sel) == i) begin
        edge_pick = rise_pol ? rise_v[i] : fall_v[i];
      end
    end
    pps_hit = sel_valid & edge_pick;
  end

endmodule

// File: rtl/tk_settings.sv
module tk_settings
  import tk_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SRC_W       = 1,
  parameter logic [31:0] DEFAULT_TPS = 32'd64_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pps_hit,
  output logic [DATA_W-1:0] pend_secs,
  output logic [DATA_W-1:0] pend_ticks,
  output logic [DATA_W-1:0] tps,
  output logic              rise_pol,
  output logic [SRC_W-1:0]  src_sel,
  output logic              armed,
  output logic              load_en
);

  localparam int unsigned FLAG_W = FLAG_SRC_LSB + SRC_W;

  logic [DATA_W-1:0] pend_secs_q, pend_secs_d;
  logic [DATA_W-1:0] pend_ticks_q, pend_ticks_d;
  logic [DATA_W-1:0] tps_q, tps_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              armed_q, armed_d;
  logic              wr_load, load_imm;

  always_comb begin
    pend_secs_d  = pend_secs_q;
    pend_ticks_d = pend_ticks_q;
    tps_d        = tps_q;
    flags_d      = flags_q;
    wr_load      = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        CFG_PEND_SECS:  pend_secs_d  = wr_data;
        CFG_PEND_TICKS: pend_ticks_d = wr_data;
        CFG_FLAGS:      flags_d      = wr_data[FLAG_W-1:0];
        CFG_LOAD:       wr_load      = 1'b1;
        CFG_TPS:        tps_d        = wr_data;
        default:        ;
      endcase
    end
    load_imm = wr_load & wr_data[0];
    if (wr_load) begin
      armed_d = ~wr_data[0];
    end else if (pps_hit) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q;
    end
    load_en = load_imm | (armed_q & pps_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_secs_q  <= '0;
      pend_ticks_q <= '0;
      tps_q        <= DATA_W'(DEFAULT_TPS);
      flags_q      <= '0;
      armed_q      <= 1'b0;
    end else begin
      pend_secs_q  <= pend_secs_d;
      pend_ticks_q <= pend_ticks_d;
      tps_q        <= tps_d;
      flags_q      <= flags_d;
      armed_q      <= armed_d;
    end
  end

  assign pend_secs  = pend_secs_q;
  assign pend_ticks = pend_ticks_q;
  assign tps        = tps_q;
  assign rise_pol   = flags_q[FLAG_POL_BIT];
  assign src_sel    = flags_q[FLAG_SRC_LSB +: SRC_W];
  assign armed      = armed_q;

endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_secs,
  input  logic [DATA_W-1:0] load_ticks,
  input  logic [DATA_W-1:0] tps,
  input  logic              cap_en,
  output logic [DATA_W-1:0] secs,
  output logic [DATA_W-1:0] ticks,
  output logic [DATA_W-1:0] cap_secs,
  output logic [DATA_W-1:0] cap_ticks
);

  logic [DATA_W-1:0] secs_q, secs_d;
  logic [DATA_W-1:0] ticks_q, ticks_d;
  logic [DATA_W-1:0] cap_secs_q, cap_secs_d;
  logic [DATA_W-1:0] cap_ticks_q, cap_ticks_d;
  logic [DATA_W:0]   ticks_inc;
  logic              wrap;

  always_comb begin
    ticks_inc = {1'b0, ticks_q} + {{DATA_W{1'b0}}, 1'b1};
    wrap      = (ticks_inc >= {1'b0, tps});
    if (load_en) begin
      secs_d  = load_secs;
      ticks_d = load_ticks;
    end else if (wrap) begin
      secs_d  = secs_q + {{(DATA_W-1){1'b0}}, 1'b1};
      ticks_d = '0;
    end else begin
      secs_d  = secs_q;
      ticks_d = ticks_inc[DATA_W-1:0];
    end
    cap_secs_d  = cap_en ? secs_q  : cap_secs_q;
    cap_ticks_d = cap_en ? ticks_q : cap_ticks_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q      <= '0;
      ticks_q     <= '0;
      cap_secs_q  <= '0;
      cap_ticks_q <= '0;
    end else begin
      secs_q      <= secs_d;
      ticks_q     <= ticks_d;
      cap_secs_q  <= cap_secs_d;
      cap_ticks_q <= cap_ticks_d;
    end
  end

  assign secs      = secs_q;
  assign ticks     = ticks_q;
  assign cap_secs  = cap_secs_q;
  assign cap_ticks = cap_ticks_q;

endmodule

// File: rtl/tk_timebase.sv
module tk_timebase
  import tk_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_PPS     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] DEFAULT_TPS = 32'd64_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [NUM_PPS-1:0] pps_in,
  input  logic [3:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int unsigned SRC_W = (NUM_PPS > 1) ? $clog2(NUM_PPS) : 1;

  logic              rst_sync_n;
  logic [DATA_W-1:0] pend_secs, pend_ticks, tps_val;
  logic              rise_pol, load_armed, load_en, pps_hit;
  logic [SRC_W-1:0]  src_sel;
  logic [DATA_W-1:0] now_secs, now_ticks, cap_secs, cap_ticks;

  tk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tk_pps_sel #(
    .NUM_SRC     (NUM_PPS),
    .SYNC_STAGES (SYNC_STAGES),
    .SRC_W       (SRC_W)
  ) u_pps (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pps_in   (pps_in),
    .src_sel  (src_sel),
    .rise_pol (rise_pol),
    .pps_hit  (pps_hit)
  );

  tk_settings #(
    .DATA_W      (DATA_W),
    .SRC_W       (SRC_W),
    .DEFAULT_TPS (DEFAULT_TPS)
  ) u_set (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (cfg_wr_en),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .pps_hit    (pps_hit),
    .pend_secs  (pend_secs),
    .pend_ticks (pend_ticks),
    .tps        (tps_val),
    .rise_pol   (rise_pol),
    .src_sel    (src_sel),
    .armed      (load_armed),
    .load_en    (load_en)
  );

  tk_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_en    (load_en),
    .load_secs  (pend_secs),
    .load_ticks (pend_ticks),
    .tps        (tps_val),
    .cap_en     (pps_hit),
    .secs       (now_secs),
    .ticks      (now_ticks),
    .cap_secs   (cap_secs),
    .cap_ticks  (cap_ticks)
  );

  always_comb begin
    unique case (rb_sel_e'(rd_addr[3:2]))
      RB_NOW_SECS:  rd_data = now_secs;
      RB_NOW_TICKS: rd_data = now_ticks;
      RB_CAP_SECS:  rd_data = cap_secs;
      RB_CAP_TICKS: rd_data = cap_ticks;
      default:      rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tk_timebase_chk.sv
module tk_timebase_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pend_secs,
  input logic [DATA_W-1:0] pend_ticks,
  input logic [DATA_W-1:0] tps,
  input logic [DATA_W-1:0] secs,
  input logic [DATA_W-1:0] ticks,
  input logic [DATA_W-1:0] cap_secs,
  input logic [DATA_W-1:0] cap_ticks,
  input logic              pps_hit,
  input logic              armed
);

  logic ctl_wr, imm_wr, any_load, will_wrap;

  always_comb begin
    ctl_wr    = wr_en && (wr_addr == 3'd3);
    imm_wr    = ctl_wr && wr_data[0];
    any_load  = imm_wr || (armed && pps_hit);
    will_wrap = (({1'b0, ticks} + 1) >= {1'b0, tps});
  end

  a_r4_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && !will_wrap) |=> (ticks == $past(ticks) + 1'b1) && $stable(secs));

  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && will_wrap) |=> (ticks == '0) && (secs == $past(secs) + 1'b1));

  a_r5_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
    imm_wr |=> (secs == $past(pend_secs)) && (ticks == $past(pend_ticks)) && !armed);

  a_r6_defer_load: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pps_hit && !imm_wr) |=> (secs == $past(pend_secs)) && (ticks == $past(pend_ticks)));

  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pps_hit && !ctl_wr) |=> !armed);

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pps_hit |=> (cap_secs == $past(secs)) && (cap_ticks == $past(ticks)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pps_hit |=> $stable(cap_secs) && $stable(cap_ticks));

endmodule

bind tk_timebase tk_timebase_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (cfg_wr_en),
  .wr_addr    (cfg_addr),
  .wr_data    (cfg_wdata),
  .pend_secs  (pend_secs),
  .pend_ticks (pend_ticks),
  .tps        (tps_val),
  .secs       (now_secs),
  .ticks      (now_ticks),
  .cap_secs   (cap_secs),
  .cap_ticks  (cap_ticks),
  .pps_hit    (pps_hit),
  .armed      (load_armed)
);

// File: tb/tk_timebase_tb_top.sv
module tk_timebase_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  pps_in;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;

  tk_timebase dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pps_in    (pps_in),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int pushed   = 0;
  int popped   = 0;
  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // reference time kept by the bench
  logic [31:0] m_s = '0, m_t = '0, m_tps = 32'd64_000_000;
  logic [31:0] p_s = '0, p_t = '0, c_s = '0, c_t = '0;
  bit          m_armed = 0;

  function automatic void adv();
    if (({1'b0, m_t} + 33'd1) >= {1'b0, m_tps}) begin
      m_t = '0;
      m_s = m_s + 1;
    end else begin
      m_t = m_t + 1;
    end
  endfunction

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic chk_now(input string tag);
    expect_rd(4'h0, m_s, tag);
    expect_rd(4'h4, m_t, tag);
  endtask

  task automatic chk_cap(input string tag);
    expect_rd(4'h8, c_s, tag);
    expect_rd(4'hC, c_t, tag);
  endtask

  // monitor: pops expected items and compares the readback port
  initial begin
    exp_item_t it;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      rd_addr = it.addr;
      #1;
      checks++;
      if (rd_data !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, rd_data, it.exp);
      end
      popped++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      adv();
      @(negedge clk);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    if (a == 3'd3 && d[0]) begin
      m_s = p_s; m_t = p_t; m_armed = 0;
    end else begin
      adv();
    end
    if (a == 3'd3 && !d[0]) m_armed = 1;
    if (a == 3'd0) p_s = d;
    if (a == 3'd1) p_t = d;
    if (a == 3'd4) m_tps = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // change one pulse line; qual says whether the requirements make it count
  task automatic pps_drive(input int idx, input logic val, input bit qual);
    pps_in[idx] = val;
    step(2);
    @(posedge clk);
    if (qual) begin
      c_s = m_s; c_t = m_t;
      if (m_armed) begin
        m_s = p_s; m_t = p_t; m_armed = 0;
      end else begin
        adv();
      end
    end else begin
      adv();
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pps_in = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_now("R1 reset now");
    chk_cap("R1 reset cap");
    rst_n = 1'b1;
    @(negedge clk);
    chk_cap("R1 after release cap");
    repeat (3) @(negedge clk);

    // R5: immediate load with R2 setting map
    cfg_write(3'd4, 32'd10);
    cfg_write(3'd0, 32'd100);
    cfg_write(3'd1, 32'd2);
    cfg_write(3'd3, 32'd1);
    chk_now("R5 immediate load");

    // R3: pending writes leave the running time alone
    cfg_write(3'd0, 32'd500);
    cfg_write(3'd1, 32'd3);
    chk_now("R3 pending write no effect");

    // R4: counting and carry at rate 10
    step(5);
    chk_now("R4 count to rate-1");
    step(1);
    chk_now("R4 carry into seconds");

    // R2: rate change below loaded ticks
    cfg_write(3'd3, 32'd1);
    chk_now("R5 second immediate load");
    cfg_write(3'd4, 32'd4);
    step(1);
    chk_now("R2 new rate forces wrap");
    cfg_write(3'd4, 32'd10);
    cfg_write(3'd2, 32'd1);
    chk_now("R3 flags and rate writes no jump");

    // R6: deferred load on rising edge of connector input
    cfg_write(3'd0, 32'd7);
    cfg_write(3'd1, 32'd5);
    cfg_write(3'd3, 32'd0);
    step(3);
    chk_now("R6 armed load waits");
    pps_drive(0, 1'b1, 1);
    chk_now("R6 deferred load at R10 latency");
    chk_cap("R9 capture pre-edge time");

    // R7: falling edge ignored with rising polarity
    pps_drive(0, 1'b0, 0);
    chk_cap("R7 wrong polarity ignored");
    chk_now("R7 wrong polarity no load");
    pps_drive(0, 1'b1, 1);
    chk_cap("R9 second capture");
    chk_now("R6 no reload after disarm");

    // R8: neighbour source selected, connector edges ignored
    cfg_write(3'd2, 32'd3);
    pps_drive(0, 1'b0, 0);
    pps_drive(0, 1'b1, 0);
    chk_cap("R8 unselected source ignored");
    pps_drive(1, 1'b1, 1);
    chk_cap("R8 selected source captured");

    // R7: falling polarity on neighbour with deferred load
    cfg_write(3'd2, 32'd2);
    cfg_write(3'd0, 32'd42);
    cfg_write(3'd1, 32'd0);
    cfg_write(3'd3, 32'd0);
    pps_drive(1, 1'b0, 1);
    chk_now("R7 falling edge loads");
    chk_cap("R7 falling edge captures");

    // R5: immediate write cancels an armed load
    cfg_write(3'd0, 32'd9);
    cfg_write(3'd1, 32'd9);
    cfg_write(3'd3, 32'd0);
    cfg_write(3'd3, 32'd1);
    chk_now("R5 immediate over armed");
    pps_drive(1, 1'b1, 0);
    pps_drive(1, 1'b0, 1);
    chk_now("R5 arm cancelled no reload");
    chk_cap("R9 capture after cancel");

    // R4: rate of one advances seconds every clock
    cfg_write(3'd4, 32'd1);
    step(2);
    chk_now("R4 rate one");

    // R11: low address bits ignored
    expect_rd(4'h1, m_s, "R11 offset 1 reads seconds");
    expect_rd(4'h6, m_t, "R11 offset 6 reads ticks");
    expect_rd(4'hB, c_s, "R11 offset 11 reads captured seconds");
    expect_rd(4'hF, c_t, "R11 offset 15 reads captured ticks");

    finished = 1;
    summary();
    $finish;
  end

endmodule